// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog that stays dormant after an external reset until software writes a two-byte key to its restart register. The first byte is 1Eh and the second is E1h. The same key both turns the watchdog on and restarts its count. Once it is on, software cannot turn it off. Only the asynchronous external reset clears it.

The count advances on a tick taken from the system clock divided by six. The period is picked by a 3-bit code held in a separate period register. When the count reaches the selected limit, the block drives a reset output high for a fixed number of clock periods. The count then starts again from zero, so a program that stops servicing the watchdog gets a reset pulse at every period.

Software reaches the block through a single-cycle register write port: a write strobe, an address and a data byte. There is no read path and no handshake. Every write with the strobe high is taken in the cycle it appears. The only output is the reset pulse.

Top module: `seq_watchdog`

## Requirements
- R1: After the external reset the watchdog is off and `wdt_rst_o` is low. The output stays low for as long as no valid key has been written.
- R2: A write of 1Eh to address A6h, followed by a write of E1h to A6h, turns the watchdog on and clears its count. Writes to other addresses may come between the two key bytes. With code c, `wdt_rst_o` rises exactly 6 × (2^(BASE_EXP+c) − 1) clock cycles after the edge that captures the E1h write. BASE_EXP is 14 by default.
- R3: The key detector follows these rules, and none of the cases below has any effect on the enable or the output:
  - A write of E1h to A6h with no 1Eh pending is ignored.
  - Any write to A6h that follows a 1Eh and is not E1h returns the detector to idle. This includes a second 1Eh.
- R4: A write to address A7h stores data bits 2:0 as the timeout code, and bits 7:3 are ignored. The code resets to 0. Each step of the code doubles the number of ticks in the period plus one.
- R5: Each reset pulse stays high for exactly PULSE_LEN clock cycles. PULSE_LEN is 96 by default.
- R6: A valid key written while the watchdog is on restarts the count from zero. The next pulse is then due one full period after that key.
- R7: The count restarts from zero at the end of each reset pulse, and the next pulse rises one full period after the previous one fell. No register write, valid or not, turns the watchdog off.
- R8: Driving `rst_n` low forces `wdt_rst_o` low at once, even in the middle of a pulse. It also turns the watchdog off, so no further pulse comes until a new key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Write data byte |
| wdt_rst_o | output | 1 | Watchdog reset pulse, active high |

## Verification
The enable takes effect at the edge that captures the E1h write. The pulse rises 6 × (2^(BASE_EXP+c) − 1) cycles after that edge, stays high for PULSE_LEN cycles, and rises again one full period after it falls. An external reset clears the output without waiting for a clock.

The bench records the cycle number of each capturing edge and of each rising and falling output edge, sampling at the falling clock edge. It compares the measured distances with these figures. It also runs a behavioural cycle model and compares the output with it at every falling clock edge. The bench shortens BASE_EXP to 4, so that even the longest code completes in about twelve thousand cycles.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;
  // Key detector state: waiting for the first key byte, or holding it
  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import seq_wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST    = 'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND   = 'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok,
  output logic              armed
);
  key_state_e state_q, state_d;
  logic       hit;

  assign hit = wr_en && (wr_addr == RESTART_ADDR);

  // R3: any restart-register write after the first key ends the attempt
  always_comb begin
    state_d = state_q;
    key_ok  = 1'b0;
    if (hit) begin
      if (state_q == KEY_IDLE) begin
        state_d = (wr_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
      end else begin
        state_d = KEY_IDLE;
        key_ok  = (wr_data == KEY_SECOND);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KEY_ARMED);
endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc_q;

  assign tick = run && !clr && (presc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              presc_q <= '0;
    else if (clr || !run)    presc_q <= '0;
    else if (presc_q == LAST) presc_q <= '0;
    else                     presc_q <= presc_q + PW'(1);
  end
endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int STEPS = 1 << SEL_W;
  localparam int CNT_W = BASE_EXP + STEPS - 1;

  logic [CNT_W-1:0] limit_tab [STEPS];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   cnt_inc;

  // R4: limit for code i is 2^(BASE_EXP+i) - 1 ticks
  for (genvar i = 0; i < STEPS; i++) begin : g_limit
    assign limit_tab[i] = CNT_W'((64'd1 << (BASE_EXP + i)) - 64'd1);
  end

  assign cnt_inc = {1'b0, count_q} + (CNT_W+1)'(1);
  // Greater-or-equal so that lowering the code mid-period still expires
  assign expire  = tick && !clr && (cnt_inc >= {1'b0, limit_tab[sel]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (clr || expire)  count_q <= '0;
    else if (tick)           count_q <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/wdt_pulse_stretch.sv
module wdt_pulse_stretch #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int PCW = $clog2(PULSE_LEN + 1);

  logic [PCW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (fire)         left_q <= PCW'(PULSE_LEN);
    else if (left_q != '0) left_q <= left_q - PCW'(1);
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'hA6,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR  = 'hA7,
  parameter logic [DATA_W-1:0] KEY_FIRST    = 'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND   = 'hE1,
  parameter int TICK_DIV  = 6,
  parameter int BASE_EXP  = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_rst_o
);
  logic             key_ok;
  logic             key_armed;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             pulse_on;
  logic             run;
  logic             tick;
  logic             expire;

  wdt_key_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESTART_ADDR(RESTART_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_ok(key_ok), .armed(key_armed)
  );

  // R7: enable is sticky, only the external reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (key_ok) en_q <= 1'b1;
  end

  // R4: only the low bits of the period register are kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  sel_q <= '0;
    else if (wr_en && (wr_addr == PERIOD_ADDR))  sel_q <= wr_data[SEL_W-1:0];
  end

  assign run = en_q && !pulse_on;

  wdt_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(key_ok), .tick(tick)
  );

  wdt_timeout_cnt #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(key_ok || !run), .tick(tick),
    .sel(sel_q), .expire(expire)
  );

  wdt_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .active(pulse_on)
  );

  assign wdt_rst_o = pulse_on;
endmodule

// File: rtl/seq_watchdog_chk.sv
module seq_watchdog_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'hA6,
  parameter logic [ADDR_W-1:0] PERIOD_ADDR  = 'hA7,
  parameter logic [DATA_W-1:0] KEY_SECOND   = 'hE1,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wdt_rst_o,
  input logic              en_q,
  input logic              armed,
  input logic [SEL_W-1:0]  sel_q
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + HW'(1);
    else                hi_cnt <= '0;
  end

  // R1
  no_pulse_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !wdt_rst_o);

  // R7
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  // R2
  key_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RESTART_ADDR && wr_data == KEY_SECOND && armed) |=> en_q);

  // R3
  lone_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RESTART_ADDR && wr_data == KEY_SECOND && !armed && !en_q) |=> !en_q);

  // R4
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PERIOD_ADDR) |=> (sel_q == $past(wr_data[SEL_W-1:0])));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> (hi_cnt == HW'(PULSE_LEN)));
endmodule

bind seq_watchdog seq_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESTART_ADDR(RESTART_ADDR),
  .PERIOD_ADDR(PERIOD_ADDR), .KEY_SECOND(KEY_SECOND),
  .SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wdt_rst_o(wdt_rst_o), .en_q(en_q),
  .armed(key_armed), .sel_q(sel_q)
);

// File: tb/tb_seq_watchdog.sv
module tb_seq_watchdog;
  localparam int BASE = 4;
  localparam int DIV  = 6;
  localparam int PLEN = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdt_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_wr = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_en, m_armed, m_sel, m_elapsed, m_left, m_lim;
  bit m_hit, m_restart;

  always #5 clk = ~clk;

  seq_watchdog #(.BASE_EXP(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_rst_o(wdt_rst_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_armed = 0; m_sel = 0; m_elapsed = 0; m_left = 0;
    end else begin
      m_hit     = wr_en && (wr_addr == 8'hA6);
      m_restart = m_hit && (m_armed != 0) && (wr_data == 8'hE1);
      m_lim     = (1 << (BASE + m_sel)) - 1;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_elapsed = 0;
      end else if (m_restart) begin
        m_elapsed = 0;
      end else if (m_en != 0) begin
        m_elapsed++;
        if ((m_elapsed % DIV) == 0 && (m_elapsed / DIV) >= m_lim) begin
          m_left = PLEN;
          m_elapsed = 0;
        end
      end
      if (m_restart) m_en = 1;
      if (m_hit) m_armed = (m_armed == 0 && wr_data == 8'h1E) ? 1 : 0;
      if (wr_en && wr_addr == 8'hA7) m_sel = int'(wr_data & 8'h07);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (wdt_rst_o !== (m_left > 0)) begin
        errors++;
        $display("FAIL %s model compare at cycle %0d: actual %0b expected %0b",
                 (m_left > 0) ? "R5" : "R2", cyc, wdt_rst_o, (m_left > 0));
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_wr = cyc;
  endtask

  task automatic key();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  task automatic wait_level(input logic lvl, output int c);
    c = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (wdt_rst_o === lvl) begin
        c = cyc;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual hung run expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, r, f, r2;
    repeat (3) @(negedge clk);
    chk("R1", int'(wdt_rst_o), 0, "output during reset");
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R1", int'(wdt_rst_o), 0, "output with no key");

    // R3: lone second key, broken sequence, repeated first key
    wr(8'hA6, 8'hE1);
    repeat (200) @(negedge clk);
    chk("R3", int'(wdt_rst_o), 0, "lone E1 ignored");
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    repeat (200) @(negedge clk);
    chk("R3", int'(wdt_rst_o), 0, "1E 55 E1 ignored");
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    repeat (200) @(negedge clk);
    chk("R3", int'(wdt_rst_o), 0, "1E 1E E1 ignored");

    // R2: key with an unrelated write between the bytes, code 0
    wr(8'hA6, 8'h1E); wr(8'h10, 8'hE1); wr(8'hA6, 8'hE1);
    k = last_wr;
    wait_level(1'b1, r);
    chk("R2", r - k, DIV * 15, "cycles from key to pulse, code 0");
    wait_level(1'b0, f);
    chk("R5", f - r, PLEN, "pulse width");
    wait_level(1'b1, r2);
    chk("R7", r2 - f, DIV * 15, "re-fire after pulse end");
    wait_level(1'b0, f);

    // R4: upper bits ignored, code 1
    wr(8'hA7, 8'hF9);
    key();
    k = last_wr;
    wait_level(1'b1, r);
    chk("R4", r - k, DIV * 31, "code 1 with upper bits set");
    wait_level(1'b0, f);

    // R6: restart mid-period
    key();
    repeat (100) @(negedge clk);
    key();
    k = last_wr;
    wait_level(1'b1, r);
    chk("R6", r - k, DIV * 31, "period measured from second key");
    wait_level(1'b0, f);

    // R4: longest code
    wr(8'hA7, 8'h07);
    key();
    k = last_wr;
    wait_level(1'b1, r);
    chk("R4", r - k, DIV * 2047, "code 7 period");
    wait_level(1'b0, f);

    // R7: stray writes cannot disable
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1); wr(8'hA7, 8'h00);
    wait_level(1'b1, r);
    chk("R7", r - f, DIV * 15, "still running after stray writes");

    // R8: async reset in mid-pulse
    repeat (10) @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R8", int'(wdt_rst_o), 0, "output cleared by async reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    chk("R8", int'(wdt_rst_o), 0, "disabled after reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule